// File: doc/BRIEF.md
# Receive Packet Admission with Low-Space Drop

This block sits between the receive stream of an Ethernet MAC and the write port of a receive FIFO. The stream is a 256-bit AXI4-Stream slave that is always ready, because the MAC receive path cannot be stalled. Each beat that is kept is written to the FIFO as one wide word. That word holds the payload bits, the end-of-packet marker and the MAC error bit.

The keep-or-discard decision is made once per packet, on its first beat, by comparing the FIFO's current fill count against a threshold. The threshold guarantees room for a maximum-size jumbo frame. An admitted packet is copied beat by beat until its last beat. A refused packet is drained without writing anything to the FIFO. Every refused packet sets a sticky overflow flag and advances a saturating drop counter. Software clears the flag with a one-cycle clear pulse.

Top module: `rx_pkt_admit`

## Requirements
- R1: `s_tready` is 1 on every cycle, during and after reset.
- R2: In idle, a beat with `s_tvalid`=1 and `fifo_wr_cnt` below 224 admits the packet. That beat appears on the write port one cycle later with `fifo_wr_en`=1.
- R3: A written word carries `s_tuser` in bit 257, `s_tlast` in bit 256 and `s_tdata` in bits 255:0.
- R4: While an admitted packet is in progress, `fifo_wr_en` one cycle later equals `s_tvalid`. Idle beats inside a packet write nothing.
- R5: A packet ends on the beat where `s_tvalid` and `s_tlast` are both 1. The next valid beat is judged afresh as a first beat, and `fifo_wr_cnt` has no effect on beats that are not first beats.
- R6: In idle, a beat with `s_tvalid`=1 and `fifo_wr_cnt` of 224 or more discards the packet. No beat of it is written, up to and including its last beat, and the block then returns to idle.
- R7: Each discarded packet sets `ovf_flag` one cycle after its first beat. The flag stays set until it is cleared.
- R8: `ovf_clr`=1 clears `ovf_flag` one cycle later. If a discard happens in the same cycle, the flag stays 1.
- R9: `drop_cnt` rises by exactly one, one cycle after the first beat of each discarded packet. `ovf_clr` does not change it.
- R10: `drop_cnt` saturates at 65535 and does not wrap.
- R11: A synchronous active-high `rst` returns the block to idle, including from the middle of a packet. It also zeroes `fifo_wr_en`, `ovf_flag` and `drop_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 256 | Stream payload beat |
| s_tvalid | input | 1 | Beat valid |
| s_tlast | input | 1 | Last beat of packet |
| s_tuser | input | 1 | MAC error marker for the packet |
| s_tready | output | 1 | Always 1 |
| fifo_wr_cnt | input | 10 | Current fill count of the receive FIFO |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 258 | Packed word {user, last, data} |
| ovf_clr | input | 1 | Pulse that clears the overflow flag |
| ovf_flag | output | 1 | Sticky flag: a packet was discarded |
| drop_cnt | output | 16 | Saturating count of discarded packets |

## Verification
A wrong packet state shows at the write port on the very next beat, in one of two ways. A state stuck in transfer writes beats of a packet that should be refused. A state stuck in flush silently swallows the next good packet. Either way, the error appears one cycle after the first beat that depends on that state. A decision taken on a non-first beat would show as a middle beat being dropped or written when the fill count crosses the threshold mid-packet. A faulty drop tracker shows in `ovf_flag` or `drop_cnt` one cycle after a refused first beat, or at the point of saturation.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_FLUSH = 2'd2
    } admit_state_e;

    typedef struct packed {
        logic write;   // store the current beat
        logic drop;    // current beat opens a refused packet
    } beat_verdict_t;

    function automatic logic has_room(input logic [31:0] fill, input logic [31:0] limit);
        return fill < limit;
    endfunction

endpackage

// File: rtl/rx_admit_fsm.sv
module rx_admit_fsm
    import rx_admit_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int ADMIT_LIMIT = 224
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_valid,
    input  logic             beat_last,
    input  logic [CNT_W-1:0] fill_cnt,
    output admit_state_e     state,
    output beat_verdict_t    verdict
);
    admit_state_e nxt;
    logic         room;
    logic         ends;

    assign room = has_room(32'(fill_cnt), 32'(ADMIT_LIMIT));
    assign ends = beat_valid && beat_last;

    always_comb begin
        nxt     = state;
        verdict = '0;
        case (state)
            ST_IDLE: begin
                if (beat_valid) begin
                    if (room) begin
                        verdict.write = 1'b1;
                        nxt = beat_last ? ST_IDLE : ST_XFER;
                    end else begin
                        verdict.drop = 1'b1;
                        nxt = beat_last ? ST_IDLE : ST_FLUSH;
                    end
                end
            end
            ST_XFER: begin
                verdict.write = beat_valid;
                if (ends) nxt = ST_IDLE;
            end
            ST_FLUSH: begin
                if (ends) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/rx_word_pack.sv
module rx_word_pack #(
    parameter int DATA_W = 256,
    localparam int WORD_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              beat_last,
    input  logic              beat_err,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_word <= '0;
        end else begin
            wr_en <= store;
            if (store) wr_word <= {beat_err, beat_last, beat_data};
        end
    end

endmodule

// File: rtl/rx_drop_tracker.sv
module rx_drop_tracker #(
    parameter int DROP_W = 16,
    localparam logic [DROP_W-1:0] DROP_MAX = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop,
    input  logic              clr,
    output logic              flag,
    output logic [DROP_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            count <= '0;
        end else begin
            if (drop)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
            if (drop && count != DROP_MAX) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rx_pkt_admit.sv
module rx_pkt_admit
    import rx_admit_pkg::*;
#(
    parameter int DATA_W      = 256,
    parameter int CNT_W       = 10,
    parameter int ADMIT_LIMIT = 224,
    parameter int DROP_W      = 16,
    localparam int WORD_W     = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    input  logic              s_tuser,
    output logic              s_tready,
    input  logic [CNT_W-1:0]  fifo_wr_cnt,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_wr_data,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic [DROP_W-1:0] drop_cnt
);
    admit_state_e  cur_state;
    beat_verdict_t verdict;

    assign s_tready = 1'b1;

    rx_admit_fsm #(.CNT_W(CNT_W), .ADMIT_LIMIT(ADMIT_LIMIT)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (s_tvalid),
        .beat_last  (s_tlast),
        .fill_cnt   (fifo_wr_cnt),
        .state      (cur_state),
        .verdict    (verdict)
    );

    rx_word_pack #(.DATA_W(DATA_W)) pack_i (
        .clk       (clk),
        .rst       (rst),
        .store     (verdict.write),
        .beat_data (s_tdata),
        .beat_last (s_tlast),
        .beat_err  (s_tuser),
        .wr_en     (fifo_wr_en),
        .wr_word   (fifo_wr_data)
    );

    rx_drop_tracker #(.DROP_W(DROP_W)) drop_i (
        .clk   (clk),
        .rst   (rst),
        .drop  (verdict.drop),
        .clr   (ovf_clr),
        .flag  (ovf_flag),
        .count (drop_cnt)
    );

endmodule

// File: rtl/rx_pkt_admit_chk.sv
module rx_pkt_admit_chk
    import rx_admit_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int ADMIT_LIMIT = 224,
    parameter int DROP_W      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              s_tvalid,
    input logic [CNT_W-1:0]  fifo_wr_cnt,
    input logic              ovf_clr,
    input logic              fifo_wr_en,
    input logic              ovf_flag,
    input logic [DROP_W-1:0] drop_cnt,
    input admit_state_e      state
);
    localparam logic [DROP_W-1:0] TOP = '1;

    logic first_ok, first_bad;
    assign first_ok  = (state == ST_IDLE) && s_tvalid && (32'(fifo_wr_cnt) <  32'(ADMIT_LIMIT));
    assign first_bad = (state == ST_IDLE) && s_tvalid && (32'(fifo_wr_cnt) >= 32'(ADMIT_LIMIT));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        first_ok |=> fifo_wr_en);

    assert_follow_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER) |=> (fifo_wr_en == $past(s_tvalid)));

    assert_reject_silent_R6: assert property (@(posedge clk) disable iff (rst)
        first_bad |=> !fifo_wr_en);

    assert_flush_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH) |=> !fifo_wr_en);

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        first_bad |=> ovf_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !first_bad) |=> !ovf_flag);

    assert_drop_step_R9: assert property (@(posedge clk) disable iff (rst)
        !first_bad |=> $stable(drop_cnt));

    assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == TOP) |=> (drop_cnt == TOP));

endmodule

bind rx_pkt_admit rx_pkt_admit_chk #(
    .CNT_W(CNT_W), .ADMIT_LIMIT(ADMIT_LIMIT), .DROP_W(DROP_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .s_tvalid    (s_tvalid),
    .fifo_wr_cnt (fifo_wr_cnt),
    .ovf_clr     (ovf_clr),
    .fifo_wr_en  (fifo_wr_en),
    .ovf_flag    (ovf_flag),
    .drop_cnt    (drop_cnt),
    .state       (cur_state)
);

// File: tb/rx_pkt_admit_tb_top.sv
module rx_pkt_admit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [255:0] s_tdata;
    logic         s_tvalid, s_tlast, s_tuser, s_tready;
    logic [9:0]   fifo_wr_cnt;
    logic         fifo_wr_en;
    logic [257:0] fifo_wr_data;
    logic         ovf_clr, ovf_flag;
    logic [15:0]  drop_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_pkt_admit dut_i (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .s_tready(s_tready),
        .fifo_wr_cnt(fifo_wr_cnt), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag), .drop_cnt(drop_cnt)
    );

    // vector: valid, last, user, fill[9:0], clr | exp_we, exp_flag, exp_drop[1:0]
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1,1'b1,1'b0,10'd10  ,1'b0, 1'b1,1'b0,2'd0}, // R2 single-beat accept
        {1'b0,1'b0,1'b0,10'd10  ,1'b0, 1'b0,1'b0,2'd0}, // idle
        {1'b1,1'b0,1'b0,10'd223 ,1'b0, 1'b1,1'b0,2'd0}, // R2 accept at 223
        {1'b1,1'b0,1'b1,10'd500 ,1'b0, 1'b1,1'b0,2'd0}, // R5 fill ignored mid-packet
        {1'b0,1'b0,1'b0,10'd500 ,1'b0, 1'b0,1'b0,2'd0}, // R4 gap
        {1'b1,1'b1,1'b0,10'd500 ,1'b0, 1'b1,1'b0,2'd0}, // R4 last beat
        {1'b1,1'b0,1'b0,10'd224 ,1'b0, 1'b0,1'b1,2'd1}, // R6 reject at 224
        {1'b1,1'b0,1'b0,10'd0   ,1'b0, 1'b0,1'b1,2'd1}, // R6 flush
        {1'b0,1'b0,1'b0,10'd0   ,1'b0, 1'b0,1'b1,2'd1}, // R6 flush gap
        {1'b1,1'b1,1'b0,10'd0   ,1'b0, 1'b0,1'b1,2'd1}, // R6 flush last
        {1'b1,1'b1,1'b1,10'd0   ,1'b0, 1'b1,1'b1,2'd1}, // R5 new first beat
        {1'b0,1'b0,1'b0,10'd0   ,1'b1, 1'b0,1'b0,2'd1}, // R8 clear
        {1'b1,1'b1,1'b0,10'd1023,1'b1, 1'b0,1'b1,2'd2}, // R8 drop beats clear
        {1'b0,1'b0,1'b0,10'd0   ,1'b1, 1'b0,1'b0,2'd2}, // R9 clear keeps count
        {1'b1,1'b1,1'b0,10'd224 ,1'b0, 1'b0,1'b1,2'd3}, // R7 single-beat drop
        {1'b1,1'b1,1'b0,10'd223 ,1'b1, 1'b1,1'b0,2'd3}  // R2 accept plus clear
    };

    function automatic logic [255:0] beat_of(input int i);
        return {8{32'h1000_0000 + 32'(i) * 32'h0101_0101}};
    endfunction

    task automatic check(input string req, input logic [257:0] act, input logic [257:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic l, input logic u,
                         input logic [9:0] f, input logic c, input logic [255:0] d);
        s_tvalid = v; s_tlast = l; s_tuser = u;
        fifo_wr_cnt = f; ovf_clr = c; s_tdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 10'd0, 1'b0, '0);
        repeat (3) @(negedge clk);
        check("R11 wr_en reset", 258'(fifo_wr_en), 258'(0));
        check("R11 flag reset",  258'(ovf_flag),   258'(0));
        check("R11 drop reset",  258'(drop_cnt),   258'(0));
        check("R1 tready in reset", 258'(s_tready), 258'(1));
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [17:0] e;
            e = VEC[i];
            drive(e[17], e[16], e[15], e[14:5], e[4], beat_of(i));
            @(negedge clk);
            check($sformatf("R4/R6 wr_en vec%0d", i), 258'(fifo_wr_en), 258'(e[3]));
            check($sformatf("R7/R8 flag vec%0d", i),  258'(ovf_flag),   258'(e[2]));
            check($sformatf("R9 drop vec%0d", i),     258'(drop_cnt),   258'(e[1:0]));
            if (e[3])
                check($sformatf("R3 word vec%0d", i), fifo_wr_data, {e[15], e[16], beat_of(i)});
        end
        check("R1 tready", 258'(s_tready), 258'(1));

        // R11: reset in the middle of an admitted packet
        drive(1'b1, 1'b0, 1'b0, 10'd5, 1'b0, beat_of(100));
        @(negedge clk);
        check("R2 mid-reset setup", 258'(fifo_wr_en), 258'(1));
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 10'd0, 1'b0, '0);
        @(negedge clk);
        check("R11 wr_en after reset", 258'(fifo_wr_en), 258'(0));
        check("R11 drop after reset",  258'(drop_cnt),   258'(0));
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 10'd300, 1'b0, beat_of(101));
        @(negedge clk);
        check("R11 idle after reset judges first beat", 258'(fifo_wr_en), 258'(0));
        check("R9 drop after reset",  258'(drop_cnt), 258'(1));
        drive(1'b1, 1'b1, 1'b0, 10'd0, 1'b0, beat_of(102));
        @(negedge clk);
        check("R6 flush last no write", 258'(fifo_wr_en), 258'(0));
        check("R9 flush beats not counted", 258'(drop_cnt), 258'(1));

        // R10: saturation
        drive(1'b1, 1'b1, 1'b0, 10'd1023, 1'b0, '0);
        repeat (65540) @(negedge clk);
        check("R10 saturate", 258'(drop_cnt), 258'(16'hFFFF));
        check("R7 flag held", 258'(ovf_flag), 258'(1));
        drive(1'b0, 1'b0, 1'b0, 10'd0, 1'b1, '0);
        @(negedge clk);
        check("R8 clear after saturation", 258'(ovf_flag), 258'(0));
        check("R9 clear leaves count",     258'(drop_cnt), 258'(16'hFFFF));
        check("R1 tready end", 258'(s_tready), 258'(1));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule